// File: doc/BRIEF.md
# Mode-Switched Program Memory Bank Allocator

This block holds the on-chip program store as sixteen RAM banks of 256 words, each word 24 bits wide, placed at the bottom of program address space. Two run-time mode bits decide which banks stay in program space. A memory-switch bit hands the upper half of the store to the X-data and Y-data ports, a quarter to each. A cache-enable bit sets aside four banks for an instruction cache. The program port decodes each address against the current internal limit. Addresses below the limit are served by the banks. Addresses at or above it become a request on the external-memory interface, and no bank sees them.

The mode bits are captured only in a cycle with no request on any of the three ports, and the new split applies from the next cycle. Bank contents are never cleared, so data written under one split can be read back under another through whichever port then owns the bank. The cache logic itself lives elsewhere. This block only gives it a bank mask showing which banks are reserved for it.

Top module: `pmem_alloc`

## Requirements
- R1: After reset the latched mode bits are both clear, `cache_rsv_o` is zero, `ext_req_o` is low, and all three read-data outputs are zero.
- R2: With both mode bits clear, program addresses 0x0000 to 0x0FFF are internal, and bank `addr[11:8]` word `addr[7:0]` holds each of them. Address 0x1000 and above is external.
- R3: With only cache-enable set, the internal limit is 0x0C00. Address 0x0BFF is internal and 0x0C00 is external.
- R4: With only memory-switch set, the internal limit is 0x0800. Address 0x07FF is internal and 0x0800 is external.
- R5: With both bits set, the internal limit is 0x0400. Address 0x03FF is internal and 0x0400 is external.
- R6: An external access raises `ext_req_o` in the same cycle, with `ext_addr_o`, `ext_we_o` and `ext_wdata_o` equal to the program-port inputs. No bank is written. This also holds for addresses in cache-reserved banks.
- R7: With memory-switch set, X address `a` (10 bits) reaches the same word as program address 0x0800+`a`, and Y address `a` reaches program address 0x0C00+`a`.
- R8: With memory-switch clear, X and Y accesses are ignored: writes change no word, and the read data in the following cycle is zero.
- R9: `cache_rsv_o` bit `b` flags bank `b`. It is 0xF000 with only cache-enable set, 0x00F0 with both bits set, and 0x0000 otherwise.
- R10: While any port request is high, changes on the mode inputs have no effect. The mode is captured in a cycle where all requests are low and applies from the next cycle.
- R11: Bank contents are kept across mode changes.
- R12: Read data appears on a port's read-data output in the cycle after an internal read request. In a cycle after anything else on that port, the output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ms_i | input | 1 | Memory-switch mode request |
| mode_ce_i | input | 1 | Cache-enable mode request |
| p_req_i | input | 1 | Program-port access strobe |
| p_we_i | input | 1 | Program-port write enable |
| p_addr_i | input | 16 | Program word address |
| p_wdata_i | input | 24 | Program write data |
| p_rdata_o | output | 24 | Program read data, one cycle after request |
| ext_req_o | output | 1 | External program access strobe |
| ext_we_o | output | 1 | External access is a write |
| ext_addr_o | output | 16 | External access address |
| ext_wdata_o | output | 24 | External write data |
| x_req_i | input | 1 | X-data access strobe |
| x_we_i | input | 1 | X-data write enable |
| x_addr_i | input | 10 | X-data window address |
| x_wdata_i | input | 24 | X-data write data |
| x_rdata_o | output | 24 | X-data read data |
| y_req_i | input | 1 | Y-data access strobe |
| y_we_i | input | 1 | Y-data write enable |
| y_addr_i | input | 10 | Y-data window address |
| y_wdata_i | input | 24 | Y-data write data |
| y_rdata_o | output | 24 | Y-data read data |
| cache_rsv_o | output | 16 | Per-bank instruction-cache reservation mask |

## Verification
The assertions check on every cycle that the external interface carries the program-port inputs and that no external request falls below the smallest internal limit. They also check that the full-size split never sends a low address outside, that the cache mask is empty or exactly four banks, that the data ports read zero while memory-switch is clear, that the mode holds while any port is busy, and that idle read outputs are zero. The exact limit in each mode, the X and Y aliasing onto program addresses, ignored data writes, and retention of contents across mode changes depend on stored data and on sequences of mode changes. Only the bench's directed scenarios can show those.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

    typedef enum logic [1:0] {
        OWN_PROG  = 2'd0,
        OWN_XDATA = 2'd1,
        OWN_YDATA = 2'd2,
        OWN_CACHE = 2'd3
    } owner_e;

endpackage

// File: rtl/pmem_bank.sv
module pmem_bank #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en_i && we_i) begin
            mem[addr_i] <= wdata_i;
        end
        if (en_i && !we_i) begin
            rdata_q <= mem[addr_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/pmem_decode.sv
module pmem_decode
    import pmem_pkg::*;
#(
    parameter int NUM_BANKS   = 16,
    parameter int BANK_DEPTH  = 256,
    parameter int XY_BANKS    = 4,
    parameter int CACHE_BANKS = 4,
    parameter int ADDR_W      = 16,
    parameter int XY_AW       = 10,
    localparam int WORD_AW    = $clog2(BANK_DEPTH),
    localparam int BANK_IW    = $clog2(NUM_BANKS),
    localparam int XY_SEL_W   = $clog2(XY_BANKS),
    localparam int LIM_W      = ADDR_W + 1
) (
    input  logic                 ms_i,
    input  logic                 ce_i,
    input  logic [ADDR_W-1:0]    p_addr_i,
    input  logic [XY_AW-1:0]     x_addr_i,
    input  logic [XY_AW-1:0]     y_addr_i,
    output logic                 p_internal_o,
    output logic [BANK_IW-1:0]   p_bank_o,
    output logic                 xy_active_o,
    output logic [BANK_IW-1:0]   x_bank_o,
    output logic [BANK_IW-1:0]   y_bank_o,
    output logic [NUM_BANKS-1:0] prog_mask_o,
    output logic [NUM_BANKS-1:0] x_mask_o,
    output logic [NUM_BANKS-1:0] y_mask_o,
    output logic [NUM_BANKS-1:0] cache_mask_o
);

    localparam int X_BASE      = NUM_BANKS - 2 * XY_BANKS;
    localparam int Y_BASE      = NUM_BANKS - XY_BANKS;
    localparam int CACHE_LO_SW = X_BASE - CACHE_BANKS;
    localparam int CACHE_LO    = NUM_BANKS - CACHE_BANKS;

    function automatic owner_e owner_of(input int b, input logic ms, input logic ce);
        owner_e o;
        o = OWN_PROG;
        if (ms) begin
            if (b >= Y_BASE)                     o = OWN_YDATA;
            else if (b >= X_BASE)                o = OWN_XDATA;
            else if (ce && b >= CACHE_LO_SW)     o = OWN_CACHE;
        end else if (ce && b >= CACHE_LO) begin
            o = OWN_CACHE;
        end
        return o;
    endfunction

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_own
        owner_e own;
        always_comb begin
            own             = owner_of(b, ms_i, ce_i);
            prog_mask_o[b]  = (own == OWN_PROG);
            x_mask_o[b]     = (own == OWN_XDATA);
            y_mask_o[b]     = (own == OWN_YDATA);
            cache_mask_o[b] = (own == OWN_CACHE);
        end
    end

    logic [BANK_IW:0]   prog_banks;
    logic [LIM_W-1:0]   limit;

    always_comb begin
        unique case ({ms_i, ce_i})
            2'b00:   prog_banks = (BANK_IW+1)'(NUM_BANKS);
            2'b01:   prog_banks = (BANK_IW+1)'(CACHE_LO);
            2'b10:   prog_banks = (BANK_IW+1)'(X_BASE);
            default: prog_banks = (BANK_IW+1)'(CACHE_LO_SW);
        endcase
        limit        = LIM_W'(prog_banks) << WORD_AW;
        p_internal_o = ({1'b0, p_addr_i} < limit);
        p_bank_o     = p_addr_i[WORD_AW +: BANK_IW];
        xy_active_o  = ms_i;
        x_bank_o     = BANK_IW'(X_BASE) + BANK_IW'(x_addr_i[WORD_AW +: XY_SEL_W]);
        y_bank_o     = BANK_IW'(Y_BASE) + BANK_IW'(y_addr_i[WORD_AW +: XY_SEL_W]);
    end

endmodule

// File: rtl/pmem_route.sv
module pmem_route #(
    parameter int NUM_BANKS  = 16,
    parameter int BANK_DEPTH = 256,
    parameter int DATA_W     = 24,
    localparam int WORD_AW   = $clog2(BANK_DEPTH),
    localparam int BANK_IW   = $clog2(NUM_BANKS)
) (
    input  logic                              p_go_i,
    input  logic                              p_we_i,
    input  logic [BANK_IW-1:0]                p_bank_i,
    input  logic [WORD_AW-1:0]                p_word_i,
    input  logic [DATA_W-1:0]                 p_wdata_i,
    input  logic                              x_go_i,
    input  logic                              x_we_i,
    input  logic [BANK_IW-1:0]                x_bank_i,
    input  logic [WORD_AW-1:0]                x_word_i,
    input  logic [DATA_W-1:0]                 x_wdata_i,
    input  logic                              y_go_i,
    input  logic                              y_we_i,
    input  logic [BANK_IW-1:0]                y_bank_i,
    input  logic [WORD_AW-1:0]                y_word_i,
    input  logic [DATA_W-1:0]                 y_wdata_i,
    input  logic [NUM_BANKS-1:0]              prog_mask_i,
    input  logic [NUM_BANKS-1:0]              x_mask_i,
    input  logic [NUM_BANKS-1:0]              y_mask_i,
    output logic [NUM_BANKS-1:0]              en_o,
    output logic [NUM_BANKS-1:0]              we_o,
    output logic [NUM_BANKS-1:0][WORD_AW-1:0] addr_o,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]  wdata_o
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        logic hit_p, hit_x, hit_y;
        always_comb begin
            hit_p = p_go_i && prog_mask_i[b] && (p_bank_i == BANK_IW'(b));
            hit_x = x_go_i && x_mask_i[b]    && (x_bank_i == BANK_IW'(b));
            hit_y = y_go_i && y_mask_i[b]    && (y_bank_i == BANK_IW'(b));
            en_o[b]    = hit_p || hit_x || hit_y;
            we_o[b]    = 1'b0;
            addr_o[b]  = '0;
            wdata_o[b] = '0;
            if (hit_p) begin
                we_o[b]    = p_we_i;
                addr_o[b]  = p_word_i;
                wdata_o[b] = p_wdata_i;
            end else if (hit_x) begin
                we_o[b]    = x_we_i;
                addr_o[b]  = x_word_i;
                wdata_o[b] = x_wdata_i;
            end else if (hit_y) begin
                we_o[b]    = y_we_i;
                addr_o[b]  = y_word_i;
                wdata_o[b] = y_wdata_i;
            end
        end
    end

endmodule

// File: rtl/pmem_alloc.sv
module pmem_alloc #(
    parameter int NUM_BANKS   = 16,
    parameter int BANK_DEPTH  = 256,
    parameter int DATA_W      = 24,
    parameter int ADDR_W      = 16,
    parameter int XY_BANKS    = 4,
    parameter int CACHE_BANKS = 4,
    localparam int WORD_AW    = $clog2(BANK_DEPTH),
    localparam int BANK_IW    = $clog2(NUM_BANKS),
    localparam int XY_AW      = $clog2(XY_BANKS * BANK_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_ms_i,
    input  logic                 mode_ce_i,
    input  logic                 p_req_i,
    input  logic                 p_we_i,
    input  logic [ADDR_W-1:0]    p_addr_i,
    input  logic [DATA_W-1:0]    p_wdata_i,
    output logic [DATA_W-1:0]    p_rdata_o,
    output logic                 ext_req_o,
    output logic                 ext_we_o,
    output logic [ADDR_W-1:0]    ext_addr_o,
    output logic [DATA_W-1:0]    ext_wdata_o,
    input  logic                 x_req_i,
    input  logic                 x_we_i,
    input  logic [XY_AW-1:0]     x_addr_i,
    input  logic [DATA_W-1:0]    x_wdata_i,
    output logic [DATA_W-1:0]    x_rdata_o,
    input  logic                 y_req_i,
    input  logic                 y_we_i,
    input  logic [XY_AW-1:0]     y_addr_i,
    input  logic [DATA_W-1:0]    y_wdata_i,
    output logic [DATA_W-1:0]    y_rdata_o,
    output logic [NUM_BANKS-1:0] cache_rsv_o
);

    typedef struct packed {
        logic               ms;
        logic               ce;
        logic               p_rd;
        logic [BANK_IW-1:0] p_bank;
        logic               x_rd;
        logic [BANK_IW-1:0] x_bank;
        logic               y_rd;
        logic [BANK_IW-1:0] y_bank;
    } state_t;

    state_t st_d, st_q;

    logic                 p_internal, xy_active;
    logic [BANK_IW-1:0]   p_bank, x_bank, y_bank;
    logic [NUM_BANKS-1:0] prog_mask, x_mask, y_mask, cache_mask;
    logic                 p_go, x_go, y_go;

    logic [NUM_BANKS-1:0]              bk_en, bk_we;
    logic [NUM_BANKS-1:0][WORD_AW-1:0] bk_addr;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  bk_wdata, bk_rdata;

    pmem_decode #(
        .NUM_BANKS  (NUM_BANKS),
        .BANK_DEPTH (BANK_DEPTH),
        .XY_BANKS   (XY_BANKS),
        .CACHE_BANKS(CACHE_BANKS),
        .ADDR_W     (ADDR_W),
        .XY_AW      (XY_AW)
    ) u_decode (
        .ms_i        (st_q.ms),
        .ce_i        (st_q.ce),
        .p_addr_i    (p_addr_i),
        .x_addr_i    (x_addr_i),
        .y_addr_i    (y_addr_i),
        .p_internal_o(p_internal),
        .p_bank_o    (p_bank),
        .xy_active_o (xy_active),
        .x_bank_o    (x_bank),
        .y_bank_o    (y_bank),
        .prog_mask_o (prog_mask),
        .x_mask_o    (x_mask),
        .y_mask_o    (y_mask),
        .cache_mask_o(cache_mask)
    );

    assign p_go = p_req_i && p_internal;
    assign x_go = x_req_i && xy_active;
    assign y_go = y_req_i && xy_active;

    pmem_route #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_DEPTH(BANK_DEPTH),
        .DATA_W    (DATA_W)
    ) u_route (
        .p_go_i     (p_go),
        .p_we_i     (p_we_i),
        .p_bank_i   (p_bank),
        .p_word_i   (p_addr_i[WORD_AW-1:0]),
        .p_wdata_i  (p_wdata_i),
        .x_go_i     (x_go),
        .x_we_i     (x_we_i),
        .x_bank_i   (x_bank),
        .x_word_i   (x_addr_i[WORD_AW-1:0]),
        .x_wdata_i  (x_wdata_i),
        .y_go_i     (y_go),
        .y_we_i     (y_we_i),
        .y_bank_i   (y_bank),
        .y_word_i   (y_addr_i[WORD_AW-1:0]),
        .y_wdata_i  (y_wdata_i),
        .prog_mask_i(prog_mask),
        .x_mask_i   (x_mask),
        .y_mask_i   (y_mask),
        .en_o       (bk_en),
        .we_o       (bk_we),
        .addr_o     (bk_addr),
        .wdata_o    (bk_wdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pmem_bank #(
            .DATA_W(DATA_W),
            .DEPTH (BANK_DEPTH)
        ) u_bank (
            .clk    (clk),
            .en_i   (bk_en[b]),
            .we_i   (bk_we[b]),
            .addr_i (bk_addr[b]),
            .wdata_i(bk_wdata[b]),
            .rdata_o(bk_rdata[b])
        );
    end

    always_comb begin
        st_d = st_q;
        if (!(p_req_i || x_req_i || y_req_i)) begin
            st_d.ms = mode_ms_i;
            st_d.ce = mode_ce_i;
        end
        st_d.p_rd   = p_go && !p_we_i;
        st_d.p_bank = p_bank;
        st_d.x_rd   = x_go && !x_we_i;
        st_d.x_bank = x_bank;
        st_d.y_rd   = y_go && !y_we_i;
        st_d.y_bank = y_bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        p_rdata_o   = st_q.p_rd ? bk_rdata[st_q.p_bank] : '0;
        x_rdata_o   = st_q.x_rd ? bk_rdata[st_q.x_bank] : '0;
        y_rdata_o   = st_q.y_rd ? bk_rdata[st_q.y_bank] : '0;
        ext_req_o   = p_req_i && !p_internal;
        ext_we_o    = ext_req_o && p_we_i;
        ext_addr_o  = ext_req_o ? p_addr_i  : '0;
        ext_wdata_o = ext_req_o ? p_wdata_i : '0;
        cache_rsv_o = cache_mask;
    end

endmodule

// File: rtl/pmem_alloc_chk.sv
module pmem_alloc_chk #(
    parameter int NUM_BANKS   = 16,
    parameter int BANK_DEPTH  = 256,
    parameter int DATA_W      = 24,
    parameter int ADDR_W      = 16,
    parameter int XY_BANKS    = 4,
    parameter int CACHE_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ms_q,
    input logic                 ce_q,
    input logic                 p_req_i,
    input logic                 p_we_i,
    input logic [ADDR_W-1:0]    p_addr_i,
    input logic                 x_req_i,
    input logic                 y_req_i,
    input logic [DATA_W-1:0]    p_rdata_o,
    input logic [DATA_W-1:0]    x_rdata_o,
    input logic [DATA_W-1:0]    y_rdata_o,
    input logic                 ext_req_o,
    input logic                 ext_we_o,
    input logic [ADDR_W-1:0]    ext_addr_o,
    input logic [NUM_BANKS-1:0] cache_rsv_o
);

    localparam int FULL_LIMIT = NUM_BANKS * BANK_DEPTH;
    localparam int MIN_LIMIT  = (NUM_BANKS - 2 * XY_BANKS - CACHE_BANKS) * BANK_DEPTH;

    AST_EXT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req_o |-> (ext_addr_o == p_addr_i && ext_we_o == p_we_i && p_req_i)); // R6

    AST_EXT_ABOVE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req_o |-> (int'(p_addr_i) >= MIN_LIMIT)); // R5

    AST_FULL_SPLIT_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_q && !ce_q && p_req_i && int'(p_addr_i) < FULL_LIMIT) |-> !ext_req_o); // R2

    AST_CACHE_MASK_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cache_rsv_o) == 0) || ($countones(cache_rsv_o) == CACHE_BANKS)); // R9

    AST_CACHE_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_q |-> (cache_rsv_o == '0)); // R9

    AST_DATA_PORTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_q |=> (x_rdata_o == '0 && y_rdata_o == '0)); // R8

    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req_i || x_req_i || y_req_i) |=> ($stable(ms_q) && $stable(ce_q))); // R10

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !p_req_i |=> (p_rdata_o == '0)); // R12

endmodule

bind pmem_alloc pmem_alloc_chk #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_DEPTH (BANK_DEPTH),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .XY_BANKS   (XY_BANKS),
    .CACHE_BANKS(CACHE_BANKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_q       (st_q.ms),
    .ce_q       (st_q.ce),
    .p_req_i    (p_req_i),
    .p_we_i     (p_we_i),
    .p_addr_i   (p_addr_i),
    .x_req_i    (x_req_i),
    .y_req_i    (y_req_i),
    .p_rdata_o  (p_rdata_o),
    .x_rdata_o  (x_rdata_o),
    .y_rdata_o  (y_rdata_o),
    .ext_req_o  (ext_req_o),
    .ext_we_o   (ext_we_o),
    .ext_addr_o (ext_addr_o),
    .cache_rsv_o(cache_rsv_o)
);

// File: tb/pmem_alloc_test.sv
module pmem_alloc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_ms_i = 1'b0, mode_ce_i = 1'b0;
    logic        p_req_i = 1'b0, p_we_i = 1'b0;
    logic [15:0] p_addr_i = '0;
    logic [23:0] p_wdata_i = '0;
    logic [23:0] p_rdata_o;
    logic        ext_req_o, ext_we_o;
    logic [15:0] ext_addr_o;
    logic [23:0] ext_wdata_o;
    logic        x_req_i = 1'b0, x_we_i = 1'b0;
    logic [9:0]  x_addr_i = '0;
    logic [23:0] x_wdata_i = '0;
    logic [23:0] x_rdata_o;
    logic        y_req_i = 1'b0, y_we_i = 1'b0;
    logic [9:0]  y_addr_i = '0;
    logic [23:0] y_wdata_i = '0;
    logic [23:0] y_rdata_o;
    logic [15:0] cache_rsv_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pmem_alloc uut (
        .clk(clk), .rst_n(rst_n), .mode_ms_i(mode_ms_i), .mode_ce_i(mode_ce_i),
        .p_req_i(p_req_i), .p_we_i(p_we_i), .p_addr_i(p_addr_i), .p_wdata_i(p_wdata_i),
        .p_rdata_o(p_rdata_o), .ext_req_o(ext_req_o), .ext_we_o(ext_we_o),
        .ext_addr_o(ext_addr_o), .ext_wdata_o(ext_wdata_o),
        .x_req_i(x_req_i), .x_we_i(x_we_i), .x_addr_i(x_addr_i), .x_wdata_i(x_wdata_i),
        .x_rdata_o(x_rdata_o), .y_req_i(y_req_i), .y_we_i(y_we_i), .y_addr_i(y_addr_i),
        .y_wdata_i(y_wdata_i), .y_rdata_o(y_rdata_o), .cache_rsv_o(cache_rsv_o)
    );

    function automatic logic [23:0] pat(input logic [15:0] a);
        return {8'h5A, a} ^ 24'h0F0F00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic ms, input logic ce);
        @(negedge clk);
        mode_ms_i = ms; mode_ce_i = ce;
        @(negedge clk);
    endtask

    task automatic p_write(input logic [15:0] a, input logic [23:0] d);
        @(negedge clk);
        p_req_i = 1; p_we_i = 1; p_addr_i = a; p_wdata_i = d;
        @(negedge clk);
        p_req_i = 0; p_we_i = 0;
    endtask

    task automatic p_read(input logic [15:0] a, output logic [23:0] d);
        @(negedge clk);
        p_req_i = 1; p_we_i = 0; p_addr_i = a;
        @(negedge clk);
        p_req_i = 0;
        d = p_rdata_o;
    endtask

    task automatic p_probe_ext(input string req, input logic [15:0] a, input logic exp);
        @(negedge clk);
        p_req_i = 1; p_we_i = 0; p_addr_i = a;
        #1 check(req, 32'(ext_req_o), 32'(exp));
        @(negedge clk);
        p_req_i = 0;
    endtask

    task automatic x_access(input logic we, input logic [9:0] a, input logic [23:0] d,
                            output logic [23:0] r);
        @(negedge clk);
        x_req_i = 1; x_we_i = we; x_addr_i = a; x_wdata_i = d;
        @(negedge clk);
        x_req_i = 0; x_we_i = 0;
        r = x_rdata_o;
    endtask

    task automatic y_access(input logic we, input logic [9:0] a, input logic [23:0] d,
                            output logic [23:0] r);
        @(negedge clk);
        y_req_i = 1; y_we_i = we; y_addr_i = a; y_wdata_i = d;
        @(negedge clk);
        y_req_i = 0; y_we_i = 0;
        r = y_rdata_o;
    endtask

    task automatic t_reset;
        check("R1 cache_rsv", 32'(cache_rsv_o), 0);
        check("R1 ext_req", 32'(ext_req_o), 0);
        check("R1 p_rdata", 32'(p_rdata_o), 0);
        check("R1 x_rdata", 32'(x_rdata_o), 0);
        check("R1 y_rdata", 32'(y_rdata_o), 0);
    endtask

    task automatic t_full_split;
        logic [23:0] r;
        set_mode(0, 0);
        p_write(16'h0000, pat(16'h0000));
        p_write(16'h0FFF, pat(16'h0FFF));
        p_write(16'h0800, pat(16'h0800));
        p_write(16'h0C00, pat(16'h0C00));
        p_write(16'h0BFF, pat(16'h0BFF));
        p_write(16'h0C01, pat(16'h0C01));
        p_read(16'h0000, r); check("R2 rd 0000", 32'(r), 32'(pat(16'h0000)));
        p_read(16'h0FFF, r); check("R12 rd 0FFF", 32'(r), 32'(pat(16'h0FFF)));
        p_read(16'h0C00, r); check("R2 rd 0C00", 32'(r), 32'(pat(16'h0C00)));
        p_probe_ext("R2 0FFF internal", 16'h0FFF, 0);
        p_probe_ext("R2 1000 external", 16'h1000, 1);
        @(negedge clk);
        p_req_i = 1; p_we_i = 1; p_addr_i = 16'h2345; p_wdata_i = 24'hABCDEF;
        #1;
        check("R6 ext_addr", 32'(ext_addr_o), 32'h2345);
        check("R6 ext_we", 32'(ext_we_o), 1);
        check("R6 ext_wdata", 32'(ext_wdata_o), 32'hABCDEF);
        @(negedge clk);
        p_req_i = 0; p_we_i = 0;
        check("R12 zero after ext", 32'(p_rdata_o), 0);
    endtask

    task automatic t_data_idle;
        logic [23:0] r;
        x_access(1, 10'h000, 24'h111111, r);
        x_access(0, 10'h000, 24'h0, r);
        check("R8 x read zero", 32'(r), 0);
        y_access(0, 10'h001, 24'h0, r);
        check("R8 y read zero", 32'(r), 0);
        p_read(16'h0800, r); check("R8 x write ignored", 32'(r), 32'(pat(16'h0800)));
    endtask

    task automatic t_cache_only;
        logic [23:0] r;
        set_mode(0, 1);
        check("R9 mask ce", 32'(cache_rsv_o), 32'hF000);
        p_probe_ext("R3 0BFF internal", 16'h0BFF, 0);
        p_probe_ext("R3 0C00 external", 16'h0C00, 1);
        p_write(16'h0C00, 24'h999999);
        p_read(16'h0BFF, r); check("R3 rd 0BFF", 32'(r), 32'(pat(16'h0BFF)));
    endtask

    task automatic t_switch_only;
        logic [23:0] r;
        set_mode(1, 0);
        check("R9 mask ms", 32'(cache_rsv_o), 0);
        p_probe_ext("R4 07FF internal", 16'h07FF, 0);
        p_probe_ext("R4 0800 external", 16'h0800, 1);
        x_access(0, 10'h000, 24'h0, r); check("R7 x alias 0800", 32'(r), 32'(pat(16'h0800)));
        y_access(0, 10'h000, 24'h0, r); check("R11 y alias 0C00", 32'(r), 32'(pat(16'h0C00)));
        x_access(1, 10'h3FF, 24'h3C3C3C, r);
        y_access(1, 10'h001, 24'h4D4D4D, r);
    endtask

    task automatic t_both;
        logic [23:0] r;
        set_mode(1, 1);
        check("R9 mask both", 32'(cache_rsv_o), 32'h00F0);
        p_probe_ext("R5 03FF internal", 16'h03FF, 0);
        p_probe_ext("R5 0400 external", 16'h0400, 1);
        x_access(0, 10'h3FF, 24'h0, r); check("R7 x read both", 32'(r), 32'h3C3C3C);
    endtask

    task automatic t_back;
        logic [23:0] r;
        set_mode(0, 0);
        check("R9 mask none", 32'(cache_rsv_o), 0);
        p_read(16'h0BFF, r); check("R11 x data kept", 32'(r), 32'h3C3C3C);
        p_read(16'h0C01, r); check("R7 y data kept", 32'(r), 32'h4D4D4D);
        p_read(16'h0C00, r); check("R6 cache write not stored", 32'(r), 32'(pat(16'h0C00)));
        p_read(16'h0000, r); check("R11 low word kept", 32'(r), 32'(pat(16'h0000)));
    endtask

    task automatic t_busy_hold;
        @(negedge clk);
        p_req_i = 1; p_we_i = 0; p_addr_i = 16'h3000;
        mode_ms_i = 1; mode_ce_i = 1;
        @(negedge clk);
        @(negedge clk);
        check("R10 mask held", 32'(cache_rsv_o), 0);
        p_addr_i = 16'h0500;
        #1 check("R10 limit held", 32'(ext_req_o), 0);
        @(negedge clk);
        p_req_i = 0;
        @(negedge clk);
        check("R10 applied after idle", 32'(cache_rsv_o), 32'h00F0);
        p_probe_ext("R10 new limit", 16'h0500, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                t_reset;
                t_full_split;
                t_data_idle;
                t_cache_only;
                t_switch_only;
                t_both;
                t_back;
                t_busy_hold;
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule